// File: doc/BRIEF.md
# Registered Transparent Memory Read Port

This block is the synchronous read side of a small multi-port RAM. The array is read without a clock, and the word it returns then passes through a chain of bypass stages, one stage for each write port. The result is captured in an output register. The read stays on the data side rather than registering the address, so the output register can have a load enable, a reset value and a defined power-up value. A write that lands on the word being read, in the same clock edge, still reaches the output.

Every write port runs on the shared clock. Each one can be marked transparent or opaque through a parameter mask. For a transparent port, each bit whose write enable is set is taken from the write data and not from the array, but only when the word addresses match. Opaque ports change only the array. The read port may be `2^RK` words wide and each write port `2^WK` words wide. Sub-words are paired by full word address, so a mismatch in width in either direction is handled.

Top module: `rdp_read_port`

## Requirements
- R1: When `rd_en` is high at a rising edge, `rd_data` takes the value read at the following edge. Sub-word `s` (bits `[s*DW +: DW]`) holds array word `rd_addr + s`. A wide port's low `RK` address bits are zero.
- R2: When `rd_en` is low and no reset takes effect, `rd_data` keeps its value.
- R3: A full write at that edge through a transparent write port to a word covered by the read appears in `rd_data` in place of the old array contents.
- R4: The bypass and the array write work per bit. Only bits whose `wr_en` bit is 1 take the write data. The other bits keep the array value.
- R5: When several write ports hit the same bit in one edge, the port with the highest index wins. This holds both in the array and in the bypass.
- R6: A write through a port whose `TRANS_MASK` bit is 0 does not show in the read made at that same edge. It shows only in later reads.
- R7: In synchronous reset mode with enable-over-reset (the default), `rd_rst` loads `RST_VAL` only while `rd_en` is high. With `rd_en` low the output holds. Writes to the array still take effect during reset.
- R8: Before any load, `rd_data` shows `INIT_VAL`.
- R9: A write at that edge to a word that the read does not cover leaves the read result unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the read port and all write ports |
| rd_rst | input | 1 | Active-high reset of the output register (sync or async by parameter) |
| rd_en | input | 1 | Active-high load enable of the output register |
| rd_addr | input | AW | Word address of the read, low RK bits zero |
| wr_en | input | NW*(DW<<WK) | Per-bit write enables, port i at slice i |
| wr_addr | input | NW*AW | Word addresses of the write ports, port i at slice i |
| wr_data | input | NW*(DW<<WK) | Write data, port i at slice i |
| rd_data | output | DW<<RK | Registered read data |

## Verification
The hardest case to reach is a single edge where two transparent ports write different nibbles of one byte that the read also covers. In that case the merged byte must come out of the bypass chain and also be left in the array. The stimulus table sets up that edge directly, with different enable halves on ports 0 and 1. Nearby rows cover a full overlap, where the higher port must win, and a same-edge write through the opaque port. A follow-up read with no write then shows what the array actually stored.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    typedef enum logic [1:0] {
        RDP_RST_NONE  = 2'd0,
        RDP_RST_SYNC  = 2'd1,
        RDP_RST_ASYNC = 2'd2
    } rst_mode_e;
endpackage

// File: rtl/rdp_mem_array.sv
module rdp_mem_array #(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int RK = 1,
    parameter int WK = 0,
    parameter int NW = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               rd_addr,
    input  logic [NW*(DW<<WK)-1:0]      wr_en,
    input  logic [NW*AW-1:0]            wr_addr,
    input  logic [NW*(DW<<WK)-1:0]      wr_data,
    output logic [(DW<<RK)-1:0]         rd_word
);
    localparam int DEPTH  = 1 << AW;
    localparam int RWORDS = 1 << RK;
    localparam int WWORDS = 1 << WK;
    localparam int WBITS  = DW << WK;

    logic [DW-1:0] mem [DEPTH];

    // R4, R5: per-bit writes, later port index applied last
    always_ff @(posedge clk) begin
        for (int p = 0; p < NW; p++) begin
            for (int w = 0; w < WWORDS; w++) begin
                for (int b = 0; b < DW; b++) begin
                    if (wr_en[p*WBITS + w*DW + b]) begin
                        mem[wr_addr[p*AW +: AW] | AW'(w)][b] <= wr_data[p*WBITS + w*DW + b];
                    end
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < RWORDS; r++) begin
            rd_word[r*DW +: DW] = mem[rd_addr | AW'(r)];
        end
    end

    // R5
    last_port_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (&wr_en[(NW-1)*WBITS +: DW]) |=>
            mem[$past(wr_addr[(NW-1)*AW +: AW])] == $past(wr_data[(NW-1)*WBITS +: DW]))
        else $error("highest write port did not win");
endmodule

// File: rtl/rdp_bypass.sv
module rdp_bypass #(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int RK = 1,
    parameter int WK = 0
) (
    input  logic [AW-1:0]        rd_addr,
    input  logic [(DW<<RK)-1:0]  data_in,
    input  logic [(DW<<WK)-1:0]  wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [(DW<<WK)-1:0]  wr_data,
    output logic [(DW<<RK)-1:0]  data_out
);
    localparam int RWORDS = 1 << RK;
    localparam int WWORDS = 1 << WK;

    // R3, R4, R9: word-level address match, bit-level enable merge
    always_comb begin
        data_out = data_in;
        for (int r = 0; r < RWORDS; r++) begin
            for (int w = 0; w < WWORDS; w++) begin
                if ((rd_addr | AW'(r)) == (wr_addr | AW'(w))) begin
                    data_out[r*DW +: DW] = (data_out[r*DW +: DW] & ~wr_en[w*DW +: DW])
                                         | (wr_data[w*DW +: DW] & wr_en[w*DW +: DW]);
                end
            end
        end
    end
endmodule

// File: rtl/rdp_outreg.sv
module rdp_outreg
    import rdp_pkg::*;
#(
    parameter int              RBITS        = 16,
    parameter rst_mode_e       RST_MODE     = RDP_RST_SYNC,
    parameter bit              CE_OVER_SRST = 1'b1,
    parameter logic [RBITS-1:0] RST_VAL     = '0,
    parameter logic [RBITS-1:0] INIT_VAL    = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [RBITS-1:0] din,
    output logic [RBITS-1:0] dout
);
    typedef struct packed {
        logic [RBITS-1:0] data;
    } out_t;

    out_t out_d;
    out_t out_q = out_t'(INIT_VAL);

    // R7: reset/enable ordering
    always_comb begin
        out_d = out_q;
        if (RST_MODE == RDP_RST_SYNC && CE_OVER_SRST) begin
            if (en) out_d.data = rst ? RST_VAL : din;
        end else if (RST_MODE == RDP_RST_SYNC && rst) begin
            out_d.data = RST_VAL;
        end else if (en) begin
            out_d.data = din;
        end
    end

    generate
        if (RST_MODE == RDP_RST_ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) out_q.data <= RST_VAL;
                else     out_q      <= out_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                out_q <= out_d;
            end
        end
    endgenerate

    assign dout = out_q.data;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q))
        else $error("output changed without enable");
endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
    import rdp_pkg::*;
#(
    parameter int                     DW           = 8,
    parameter int                     AW           = 4,
    parameter int                     RK           = 1,
    parameter int                     WK           = 0,
    parameter int                     NW           = 3,
    parameter logic [NW-1:0]          TRANS_MASK   = 3'b011,
    parameter rst_mode_e              RST_MODE     = RDP_RST_SYNC,
    parameter bit                     CE_OVER_SRST = 1'b1,
    parameter logic [(DW<<RK)-1:0]    RST_VAL      = 'hDEAD,
    parameter logic [(DW<<RK)-1:0]    INIT_VAL     = 'hA5A5
) (
    input  logic                      clk,
    input  logic                      rd_rst,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    input  logic [NW*(DW<<WK)-1:0]    wr_en,
    input  logic [NW*AW-1:0]          wr_addr,
    input  logic [NW*(DW<<WK)-1:0]    wr_data,
    output logic [(DW<<RK)-1:0]       rd_data
);
    localparam int RBITS = DW << RK;
    localparam int WBITS = DW << WK;
    localparam logic [AW-1:0] RLOW = AW'((1 << RK) - 1);
    localparam logic [AW-1:0] WLOW = AW'((1 << WK) - 1);

    logic [RBITS-1:0] arr_word;
    logic [RBITS-1:0] chain [NW+1];

    rdp_mem_array #(.DW(DW), .AW(AW), .RK(RK), .WK(WK), .NW(NW)) u_array (
        .clk     (clk),
        .rst     (rd_rst),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_word (arr_word)
    );

    assign chain[0] = arr_word;

    // R5, R6: stages in port order; opaque ports pass through
    generate
        for (genvar p = 0; p < NW; p++) begin : g_stage
            if (TRANS_MASK[p]) begin : g_trans
                rdp_bypass #(.DW(DW), .AW(AW), .RK(RK), .WK(WK)) u_byp (
                    .rd_addr  (rd_addr),
                    .data_in  (chain[p]),
                    .wr_en    (wr_en[p*WBITS +: WBITS]),
                    .wr_addr  (wr_addr[p*AW +: AW]),
                    .wr_data  (wr_data[p*WBITS +: WBITS]),
                    .data_out (chain[p+1])
                );
            end else begin : g_opaque
                assign chain[p+1] = chain[p];
            end
        end
    endgenerate

    rdp_outreg #(
        .RBITS(RBITS), .RST_MODE(RST_MODE), .CE_OVER_SRST(CE_OVER_SRST),
        .RST_VAL(RST_VAL), .INIT_VAL(INIT_VAL)
    ) u_out (
        .clk  (clk),
        .rst  (rd_rst),
        .en   (rd_en),
        .din  (chain[NW]),
        .dout (rd_data)
    );

    // R1
    load_latency_chk: assert property (@(posedge clk) disable iff (rd_rst)
        rd_en |=> rd_data == $past(chain[NW]))
        else $error("registered read mismatch");

    // R1
    rd_align_chk: assert property (@(posedge clk) disable iff (rd_rst)
        rd_en |-> (rd_addr & RLOW) == '0)
        else $error("wide read address not aligned");

    // R1
    wr_align_chk: assert property (@(posedge clk) disable iff (rd_rst)
        (|wr_en[WBITS-1:0]) |-> (wr_addr[AW-1:0] & WLOW) == '0)
        else $error("wide write address not aligned");
endmodule

// File: tb/rdp_read_port_tb.sv
module rdp_read_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rd_rst = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [23:0] wr_en = '0;
    logic [11:0] wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdp_read_port u_dut (
        .clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        en;
        logic [3:0]  ra;
        logic [23:0] we;
        logic [11:0] wa;
        logic [23:0] wd;
        logic [15:0] exp;
    } vec_t;

    // port i: we/wd bits [8i+7:8i], wa bits [4i+3:4i]; array word a preloaded with 8'h10+a
    localparam vec_t VECS [13] = '{
        '{4'd1, 1'b1, 4'd2,  24'h000000, 12'h000, 24'h000000, 16'h1312}, // R1
        '{4'd3, 1'b1, 4'd4,  24'h0000FF, 12'h005, 24'h0000AA, 16'hAA14}, // R3
        '{4'd1, 1'b1, 4'd4,  24'h000000, 12'h000, 24'h000000, 16'hAA14}, // R1
        '{4'd4, 1'b1, 4'd6,  24'h00000F, 12'h006, 24'h0000FF, 16'h171F}, // R4
        '{4'd5, 1'b1, 4'd8,  24'h00FFFF, 12'h088, 24'h002211, 16'h1922}, // R5
        '{4'd6, 1'b1, 4'd10, 24'hFF0000, 12'hA00, 24'h330000, 16'h1B1A}, // R6
        '{4'd6, 1'b1, 4'd10, 24'h000000, 12'h000, 24'h000000, 16'h1B33}, // R6
        '{4'd2, 1'b0, 4'd12, 24'h0000FF, 12'h00C, 24'h000044, 16'h1B33}, // R2
        '{4'd1, 1'b1, 4'd12, 24'h000000, 12'h000, 24'h000000, 16'h1D44}, // R1
        '{4'd4, 1'b1, 4'd14, 24'h00F000, 12'h0F0, 24'h005500, 16'h5F1E}, // R4
        '{4'd5, 1'b1, 4'd0,  24'h000FF0, 12'h011, 24'h00CDAB, 16'hAD10}, // R5
        '{4'd9, 1'b1, 4'd0,  24'h0000FF, 12'h002, 24'h000099, 16'hAD10}, // R9
        '{4'd9, 1'b1, 4'd2,  24'h000000, 12'h000, 24'h000000, 16'h1399}  // R9
    };

    task automatic check(input int req, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL R%0d: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the next rising edge
    task automatic step(input logic rst, input logic en, input logic [3:0] ra,
                        input logic [23:0] we, input logic [11:0] wa, input logic [23:0] wd);
        rd_rst = rst; rd_en = en; rd_addr = ra;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        rd_rst = 1'b0; rd_en = 1'b0; wr_en = '0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0, 4'd0, 24'h0, 12'h0, 24'h0);
        check(8, 16'hA5A5); // R8 power-up value
        for (int a = 0; a < 16; a++) begin
            step(1'b0, 1'b0, 4'd0, 24'h0000FF, {8'h00, 4'(a)}, {16'h0000, 8'(8'h10 + a)});
        end
        check(2, 16'hA5A5); // R2 no load during prefill
        for (int i = 0; i < 13; i++) begin
            step(1'b0, VECS[i].en, VECS[i].ra, VECS[i].we, VECS[i].wa, VECS[i].wd);
            check(int'(VECS[i].req), VECS[i].exp);
        end
        // R7: reset with enable loads reset value
        step(1'b1, 1'b1, 4'd0, 24'h0, 12'h0, 24'h0);
        check(7, 16'hDEAD);
        step(1'b0, 1'b1, 4'd4, 24'h0, 12'h0, 24'h0);
        check(1, 16'hAA14);
        // R7: reset without enable holds
        step(1'b1, 1'b0, 4'd0, 24'h0, 12'h0, 24'h0);
        check(7, 16'hAA14);
        // R7: array write during reset still lands
        step(1'b1, 1'b1, 4'd4, 24'h0000FF, 12'h004, 24'h000077);
        check(7, 16'hDEAD);
        step(1'b0, 1'b1, 4'd4, 24'h0, 12'h0, 24'h0);
        check(7, 16'hAA77);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule